// File: doc/BRIEF.md
# Exception Priority Resolution Unit

This block sits beside a small processor core and decides, every cycle, whether a pending exception should preempt the one that is running. It keeps a pending bit for each source. Reset, the non-maskable interrupt and hard fault have fixed negative priorities. The remaining sources are memory-management fault, bus fault, usage fault, supervisor call, debug monitor, PendSV, SysTick and a parameterised set of external IRQs. Each of these has a 3-bit priority and an enable bit.

Hardware strobes and software set-pending bits make a source pending. It stays pending until the core acknowledges that exception number. A fault that is disabled, or that cannot preempt the active priority, is moved into the hard-fault pending state. The outputs show the winning exception number and its effective priority, together with a take signal, in the cycle after the pending state changes.

Top module: `exc_prio_unit`

## Requirements
- R1: A reset request is taken as number 1 with priority -3 at any active priority, and it outranks every other pending source.
- R2: Any bit of the four non-maskable cause inputs makes number 2 pending. It is taken with priority -2 whenever the active priority is above -2, whatever the enable bits, and only reset beats it.
- R3: Hard fault is number 3 with priority -1 and beats every configurable source, whatever that source's priority.
- R4: A pending memory-management fault (index 0), bus fault (index 1) or usage fault (index 2) escalates on the next clock edge. This happens when its enable is low or its priority is not strictly below the active priority. At that edge its own pending bit clears and hard fault becomes pending.
- R5: A configurable source that is not a fault and is disabled stays pending without being taken or escalated. It is taken once its enable is set.
- R6: The debug monitor (index 4, number 12) is taken only while its enable is set and its priority is strictly below the active priority.
- R7: PendSV (index 5, number 14) and SysTick (index 6, number 15) become pending through the software set-pending bits. SysTick also becomes pending through its hardware strobe.
- R8: An exception is taken only when its effective priority is strictly lower in value than `act_prio_i`. Thread mode is encoded as active priority 8.
- R9: Among eligible configurable sources, the lowest priority value wins. Ties go to the lowest exception number.
- R10: After reset nothing is pending and `take_o` is low. A pending bit holds until an acknowledge carrying its number arrives. A new request in the same cycle as that acknowledge keeps the bit set.
- R11: Configurable index i uses priority bits `cfg_prio_i[3*i +: 3]`. Index 3 is number 11 and index 7+k is IRQ number 16+k. The outputs reflect a request right after the clock edge that captured it, and when `take_o` is low they are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rst_req_i | input | 1 | Reset exception request strobe |
| nmi_src_i | input | 4 | Non-maskable cause strobes: clock fail, remote watchdog, vector fetch error, pin trigger |
| hf_req_i | input | 1 | Direct hard-fault request strobe |
| cfg_req_i | input | 7+N_IRQ | Hardware request strobes of configurable sources |
| sw_pend_i | input | 7+N_IRQ | Software set-pending bits of configurable sources |
| cfg_en_i | input | 7+N_IRQ | Per-source enables |
| cfg_prio_i | input | 3*(7+N_IRQ) | Packed per-source priorities |
| act_prio_i | input | 5 | Signed current active priority, 8 in thread mode |
| ack_i | input | 1 | Acknowledge strobe |
| ack_num_i | input | 8 | Exception number being acknowledged |
| take_o | output | 1 | A pending exception should preempt |
| exc_num_o | output | 8 | Winning exception number |
| exc_prio_o | output | 5 | Signed effective priority of the winner |

## Verification
Two things can land on the same clock edge. An acknowledge can clear a pending bit while a new request sets that same bit. A fault can also escalate while the core is still acknowledging a hard fault. The bench drives an IRQ request together with the acknowledge of that IRQ's number, and expects the IRQ to remain the winner afterwards. It also acknowledges a hard fault produced by escalation, then checks over the following cycles that the original fault does not reappear.

// File: rtl/exc_prio_pkg.sv
package exc_prio_pkg;
  localparam int unsigned NUM_W     = 8;
  localparam int unsigned N_SYS_CFG = 7;
  localparam int unsigned IRQ_BASE  = 16;

  localparam logic [NUM_W-1:0] NUM_RESET = 8'd1;
  localparam logic [NUM_W-1:0] NUM_NMI   = 8'd2;
  localparam logic [NUM_W-1:0] NUM_HARD  = 8'd3;

  // configurable index -> exception number
  function automatic logic [NUM_W-1:0] cfg_num(input int unsigned idx);
    logic [NUM_W-1:0] n;
    case (idx)
      0:       n = 8'd4;
      1:       n = 8'd5;
      2:       n = 8'd6;
      3:       n = 8'd11;
      4:       n = 8'd12;
      5:       n = 8'd14;
      6:       n = 8'd15;
      default: n = NUM_W'(IRQ_BASE + idx - N_SYS_CFG);
    endcase
    return n;
  endfunction
endpackage

// File: rtl/exc_pend_bank.sv
module exc_pend_bank #(
  parameter int unsigned N = 15
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= set_i | (pend_q & ~clr_i);
  end

  assign pend_o = pend_q;

  for (genvar g = 0; g < N; g++) begin : g_chk
    assert_pend_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_q[g] && !clr_i[g]) |=> pend_q[g]);
    assert_set_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> pend_q[g]);
  end
endmodule

// File: rtl/exc_cfg_arb.sv
module exc_cfg_arb #(
  parameter int unsigned N      = 15,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned ACT_W  = PRIO_W + 2,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N-1:0]            pend_i,
  input  logic [N-1:0]            en_i,
  input  logic [N*PRIO_W-1:0]     prio_i,
  input  logic signed [ACT_W-1:0] act_i,
  output logic [N-1:0]            block_o,
  output logic                    valid_o,
  output logic [IDX_W-1:0]        idx_o,
  output logic [PRIO_W-1:0]       prio_o
);
  logic [N-1:0] elig;

  for (genvar g = 0; g < N; g++) begin : g_elig
    logic signed [ACT_W-1:0] pe;
    assign pe         = $signed({{(ACT_W-PRIO_W){1'b0}}, prio_i[g*PRIO_W +: PRIO_W]});
    assign elig[g]    = pend_i[g] && en_i[g] && (pe < act_i);
    assign block_o[g] = pend_i[g] && !elig[g];
  end

  // strict compare keeps the lowest index on ties
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    prio_o  = '1;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && (!valid_o || prio_i[i*PRIO_W +: PRIO_W] < prio_o)) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
        prio_o  = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end

  assert_win_eligible_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (pend_i[idx_o] && en_i[idx_o]));
  assert_no_win_when_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i == '0) |-> !valid_o);
endmodule

// File: rtl/exc_prio_unit.sv
module exc_prio_unit
  import exc_prio_pkg::*;
#(
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned N_IRQ  = 8,
  localparam int unsigned NCFG  = N_SYS_CFG + N_IRQ,
  localparam int unsigned ACT_W = PRIO_W + 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    rst_req_i,
  input  logic [3:0]              nmi_src_i,
  input  logic                    hf_req_i,
  input  logic [NCFG-1:0]         cfg_req_i,
  input  logic [NCFG-1:0]         sw_pend_i,
  input  logic [NCFG-1:0]         cfg_en_i,
  input  logic [NCFG*PRIO_W-1:0]  cfg_prio_i,
  input  logic signed [ACT_W-1:0] act_prio_i,
  input  logic                    ack_i,
  input  logic [NUM_W-1:0]        ack_num_i,
  output logic                    take_o,
  output logic [NUM_W-1:0]        exc_num_o,
  output logic signed [ACT_W-1:0] exc_prio_o
);
  localparam int unsigned IDX_W = $clog2(NCFG);
  localparam int unsigned N_FLT = 3;
  localparam logic signed [ACT_W-1:0] P_RESET = -3;
  localparam logic signed [ACT_W-1:0] P_NMI   = -2;
  localparam logic signed [ACT_W-1:0] P_HARD  = -1;

  logic rst_pend_q, nmi_pend_q, hf_pend_q;
  logic [NCFG-1:0] cfg_pend, cfg_set, cfg_clr, cfg_block, esc;
  logic arb_valid;
  logic [IDX_W-1:0]  arb_idx;
  logic [PRIO_W-1:0] arb_prio;

  // faults escalate when blocked; other sources just wait
  for (genvar g = 0; g < NCFG; g++) begin : g_cfg
    if (g < N_FLT) begin : g_flt
      assign esc[g] = cfg_block[g];
    end else begin : g_oth
      assign esc[g] = 1'b0;
    end
    assign cfg_set[g] = cfg_req_i[g] | sw_pend_i[g];
    assign cfg_clr[g] = esc[g] | (ack_i && ack_num_i == cfg_num(g));
  end

  exc_pend_bank #(.N(NCFG)) u_pend (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (cfg_set),
    .clr_i (cfg_clr),
    .pend_o(cfg_pend)
  );

  exc_cfg_arb #(.N(NCFG), .PRIO_W(PRIO_W), .ACT_W(ACT_W)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pend_i (cfg_pend),
    .en_i   (cfg_en_i),
    .prio_i (cfg_prio_i),
    .act_i  (act_prio_i),
    .block_o(cfg_block),
    .valid_o(arb_valid),
    .idx_o  (arb_idx),
    .prio_o (arb_prio)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_pend_q <= 1'b0;
      nmi_pend_q <= 1'b0;
      hf_pend_q  <= 1'b0;
    end else begin
      rst_pend_q <= rst_req_i  | (rst_pend_q & ~(ack_i && ack_num_i == NUM_RESET));
      nmi_pend_q <= |nmi_src_i | (nmi_pend_q & ~(ack_i && ack_num_i == NUM_NMI));
      hf_pend_q  <= hf_req_i | (|esc) | (hf_pend_q & ~(ack_i && ack_num_i == NUM_HARD));
    end
  end

  always_comb begin
    take_o     = 1'b0;
    exc_num_o  = '0;
    exc_prio_o = '0;
    if (rst_pend_q) begin
      take_o = 1'b1; exc_num_o = NUM_RESET; exc_prio_o = P_RESET;
    end else if (nmi_pend_q && act_prio_i > P_NMI) begin
      take_o = 1'b1; exc_num_o = NUM_NMI; exc_prio_o = P_NMI;
    end else if (hf_pend_q && act_prio_i > P_HARD) begin
      take_o = 1'b1; exc_num_o = NUM_HARD; exc_prio_o = P_HARD;
    end else if (arb_valid) begin
      take_o     = 1'b1;
      exc_num_o  = cfg_num(int'(arb_idx));
      exc_prio_o = $signed({{(ACT_W-PRIO_W){1'b0}}, arb_prio});
    end
  end

  assert_strict_preempt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (exc_prio_o < act_prio_i));
  assert_reset_wins_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_pend_q |-> (take_o && exc_num_o == NUM_RESET));
  assert_nmi_over_rest_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_pend_q && !rst_pend_q && act_prio_i > P_NMI) |-> (exc_num_o == NUM_NMI));
  assert_hard_over_cfg_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && exc_prio_o >= 0) |-> !(hf_pend_q && act_prio_i > P_HARD));
  assert_disabled_fault_escalates_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_pend[1] && !cfg_en_i[1]) |=> (hf_pend_q && !cfg_pend[1]));
  assert_dbg_gated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && exc_num_o == 8'd12) |-> cfg_en_i[4]);
endmodule

// File: tb/exc_prio_unit_tb.sv
module exc_prio_unit_tb_top;
  localparam int PW = 3;
  localparam int NI = 8;
  localparam int NC = 7 + NI;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rst_req = 1'b0;
  logic [3:0] nmi_src = '0;
  logic hf_req = 1'b0;
  logic [NC-1:0] cfg_req = '0, sw_pend = '0, cfg_en = '1;
  logic [NC*PW-1:0] cfg_prio = '1;
  logic signed [4:0] act = 5'sd8;
  logic ack = 1'b0;
  logic [7:0] ack_num = '0;
  logic take;
  logic [7:0] num;
  logic signed [4:0] prio;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { bit t; int n; int p; string tag; } exp_t;
  exp_t q[$];
  event sample_ev;

  always #5 clk = ~clk;

  exc_prio_unit #(.PRIO_W(PW), .N_IRQ(NI)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rst_req_i(rst_req), .nmi_src_i(nmi_src),
    .hf_req_i(hf_req), .cfg_req_i(cfg_req), .sw_pend_i(sw_pend), .cfg_en_i(cfg_en),
    .cfg_prio_i(cfg_prio), .act_prio_i(act), .ack_i(ack), .ack_num_i(ack_num),
    .take_o(take), .exc_num_o(num), .exc_prio_o(prio)
  );

  task automatic cyc();
    @(posedge clk); #2;
  endtask

  task automatic expect_out(bit t, int n, int p, string tag);
    exp_t e;
    e.t = t; e.n = n; e.p = p; e.tag = tag;
    q.push_back(e);
    ->sample_ev;
    #1;
  endtask

  task automatic set_prio(int idx, int p);
    cfg_prio[idx*PW +: PW] = PW'(p);
  endtask

  task automatic pulse_cfg(int idx, bit sw);
    if (sw) sw_pend[idx] = 1'b1; else cfg_req[idx] = 1'b1;
    cyc();
    sw_pend = '0; cfg_req = '0;
  endtask

  task automatic do_ack(int n);
    ack = 1'b1; ack_num = 8'(n);
    cyc();
    ack = 1'b0;
  endtask

  // monitor: compare design outputs with queued expectations
  initial begin
    forever begin
      @(sample_ev);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (take !== e.t || (e.t && (int'(num) != e.n || int'(prio) != e.p)) ||
            (!e.t && (num !== 8'd0 || prio !== 5'sd0))) begin
          errors++;
          $display("FAIL %s: got take=%0b num=%0d prio=%0d, expected take=%0b num=%0d prio=%0d",
                   e.tag, take, num, prio, e.t, e.n, e.p);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    cyc();
    expect_out(0, 0, 0, "R10 reset state");

    // basic IRQ numbering and prio field (R11)
    set_prio(9, 5);
    pulse_cfg(9, 0);
    expect_out(1, 18, 5, "R11 irq2 number/prio");
    do_ack(18);
    expect_out(0, 0, 0, "R10 ack clears");

    // strict preemption (R8)
    act = 5'sd4;
    pulse_cfg(9, 0);
    expect_out(0, 0, 0, "R8 lower urgency held");
    act = 5'sd5; cyc();
    expect_out(0, 0, 0, "R8 equal priority not taken");
    act = 5'sd6; cyc();
    expect_out(1, 18, 5, "R8 taken when strictly higher, R10 held");
    do_ack(18); act = 5'sd8;

    // tie break (R9)
    set_prio(7, 2); set_prio(10, 2);
    cfg_req[7] = 1; cfg_req[10] = 1; cyc(); cfg_req = '0;
    expect_out(1, 16, 2, "R9 tie to lowest number");
    do_ack(16);
    expect_out(1, 19, 2, "R9 remaining irq");
    do_ack(19);
    set_prio(12, 1); set_prio(10, 3);
    cfg_req[10] = 1; cfg_req[12] = 1; cyc(); cfg_req = '0;
    expect_out(1, 21, 1, "R9 lower value beats lower number");
    do_ack(21); do_ack(19);
    expect_out(0, 0, 0, "R9 drained");

    // NMI and reset (R1, R2)
    set_prio(8, 0);
    pulse_cfg(8, 0);
    expect_out(1, 17, 0, "R11 irq1 prio0");
    nmi_src[2] = 1; cyc(); nmi_src = '0;
    expect_out(1, 2, -2, "R2 nmi beats prio0");
    cfg_en = '0; cyc();
    expect_out(1, 2, -2, "R2 nmi ignores enables");
    cfg_en = '1;
    act = -5'sd2; cyc();
    expect_out(0, 0, 0, "R2 nothing preempts nmi");
    rst_req = 1; cyc(); rst_req = 0;
    expect_out(1, 1, -3, "R1 reset preempts nmi");
    do_ack(1);
    expect_out(0, 0, 0, "R1 reset acked");
    act = 5'sd8; cyc();
    expect_out(1, 2, -2, "R2 nmi still pending");
    do_ack(2);
    expect_out(1, 17, 0, "R10 irq held under nmi");

    // hard fault (R3)
    hf_req = 1; cyc(); hf_req = 0;
    expect_out(1, 3, -1, "R3 hard fault over cfg");
    do_ack(3); do_ack(17);
    expect_out(0, 0, 0, "R3 drained");

    // escalation of disabled bus fault (R4)
    cfg_en[1] = 0;
    pulse_cfg(1, 0);
    expect_out(0, 0, 0, "R4 disabled bus fault not taken");
    cyc();
    expect_out(1, 3, -1, "R4 escalated to hard fault");
    do_ack(3);
    expect_out(0, 0, 0, "R4 escalated fault consumed");
    cyc();
    expect_out(0, 0, 0, "R4 no reappearance");
    cfg_en[1] = 1; set_prio(1, 4);
    pulse_cfg(1, 0);
    expect_out(1, 5, 4, "R4 enabled bus fault taken");
    do_ack(5);

    // escalation by priority (R4)
    set_prio(2, 4); act = 5'sd3;
    pulse_cfg(2, 0);
    expect_out(0, 0, 0, "R4 blocked usage fault");
    cyc();
    expect_out(1, 3, -1, "R4 usage escalated by priority");
    do_ack(3); act = 5'sd8; cyc();
    expect_out(0, 0, 0, "R4 usage cleared");

    // disabled non-fault waits (R5, R7)
    cfg_en[6] = 0;
    pulse_cfg(6, 1);
    expect_out(0, 0, 0, "R5 disabled systick held");
    cyc();
    expect_out(0, 0, 0, "R5 no escalation");
    cfg_en[6] = 1; cyc();
    expect_out(1, 15, 7, "R5 R7 systick after enable");
    do_ack(15);
    pulse_cfg(6, 0);
    expect_out(1, 15, 7, "R7 systick hw strobe");
    do_ack(15);
    pulse_cfg(5, 1);
    expect_out(1, 14, 7, "R7 pendsv software");
    do_ack(14);
    pulse_cfg(3, 0);
    expect_out(1, 11, 7, "R11 svc number");
    do_ack(11);

    // debug monitor gating (R6)
    cfg_en[4] = 0;
    pulse_cfg(4, 0);
    expect_out(0, 0, 0, "R6 debug monitor disabled");
    cfg_en[4] = 1; set_prio(4, 3); act = 5'sd2; cyc();
    expect_out(0, 0, 0, "R6 debug monitor lower than active");
    act = 5'sd8; cyc();
    expect_out(1, 12, 3, "R6 debug monitor taken");
    do_ack(12);

    // set and ack in same cycle (R10)
    pulse_cfg(8, 0);
    expect_out(1, 17, 0, "R10 irq1 pending");
    ack = 1; ack_num = 8'd17; cfg_req[8] = 1; cyc();
    ack = 0; cfg_req = '0;
    expect_out(1, 17, 0, "R10 set wins over ack");
    do_ack(17);
    expect_out(0, 0, 0, "R10 final drain");

    cyc();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule